// File: doc/BRIEF.md
# Serial framed relay controller

This block listens on an asynchronous serial line and turns a fixed four-byte command frame into the levels of sixteen relay drivers. A byte-level receiver recovers 8N1 characters by oversampling the line. A window controller gathers the received characters into a small frame store and decides what to do with them only when a timeout window closes.

The window opens on the first character that arrives while the controller is idle. At that moment the store is cleared, the character lands in the first slot and a window timer starts from zero. Later characters fill the following slots; any beyond the fourth are dropped. When the timer runs out, the controller accepts the frame only if it begins with 0x0A and ends with 0x0D. An accepted frame copies its two middle bytes onto the two relay banks and raises a one-cycle accept pulse. A rejected frame zeroes the store, leaves the relays untouched and raises a one-cycle reject pulse. Nothing is sent back to the sender.

The line rate, the oversampling factor, the timer prescaler and the window length are all parameters. The defaults give 9600 baud from a 100 MHz clock and a window of 65536 ticks of about 1.08 µs each.

Top module: `relay_frame_ctrl`

## Requirements
- R1: Characters are 8N1, least significant bit first, sampled at OVERSAMPLE times the bit rate. A falling edge starts a character only if the line is still low at the middle of the start bit; a shorter low glitch produces nothing.
- R2: A character whose stop bit samples low is discarded. It opens no window and fills no slot.
- R3: A character received while idle opens a window. All four slots are cleared, that character is stored in slot 0, later characters go into slots 1, 2 and 3 in arrival order, and the window timer starts from zero.
- R4: The frame is judged only when the window timer expires, never when the fourth character arrives. Before expiry the relay outputs do not change.
- R5: If slot 0 holds 0x0A and slot 3 holds 0x0D at expiry, relay_lo takes slot 1 (bit i drives relay i+1) and relay_hi takes slot 2 (bit i drives relay i+9). frame_ok pulses high for one cycle, in the same cycle the relays take their new values.
- R6: If slot 0 is not 0x0A or slot 3 is not 0x0D at expiry, frame_err pulses for one cycle, all slots are zeroed and both relay banks keep their previous values.
- R7: Characters after the fourth within one window are dropped. A character that arrives while a window is open or being judged opens no new window.
- R8: After reset both relay banks are 0x00 and neither status pulse is high.
- R9: Each window ends in exactly one status pulse, frame_ok or frame_err, never both, each lasting one cycle.
- R10: A window that collects fewer than four characters is judged with zeros in the missing slots. It is rejected even if an earlier accepted frame had left 0x0D in slot 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| relay_lo | output | 8 | Relay bank for relays 1 to 8 |
| relay_hi | output | 8 | Relay bank for relays 9 to 16 |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| frame_err | output | 1 | One-cycle pulse: frame rejected |

## Verification
The hardest cases to reach from the pins are a stale end byte left over from an earlier accepted frame, and a character dropped in the middle of a window. The first shows only if a short frame follows a good one, so the bench sends a three-character frame right after an accepted frame and expects a rejection. The second needs a bad stop bit inside an otherwise valid frame followed by an extra character. The relays then show the bytes that survived rather than the bytes that were shifted out. Extra trailing characters and lone bad-stop characters are followed by a quiet interval, in which the scoreboard fails any status pulse it did not expect.

// File: rtl/relay_frame_pkg.sv
package relay_frame_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned FRAME_LEN = 4;
   localparam logic [BYTE_W-1:0] SYNC_CODE = 8'h0A;
   localparam logic [BYTE_W-1:0] END_CODE  = 8'h0D;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_t;

   typedef enum logic [1:0] {
      W_IDLE,
      W_COLLECT,
      W_CHECK
   } win_state_t;
endpackage

// File: rtl/rfc_tick_gen.sv
module rfc_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rfc_tick_gen: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == CW'(DIV - 1)) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   a_r1_tick_single : assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
endmodule

// File: rtl/rfc_uart_rx.sv
module rfc_uart_rx
   import relay_frame_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              os_tick,
   input  logic              rx,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data
);
   localparam int unsigned OS_CW  = $clog2(OVERSAMPLE);
   localparam int unsigned BIT_CW = $clog2(BYTE_W);
   localparam int unsigned HALF   = OVERSAMPLE / 2;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("rfc_uart_rx: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("rfc_uart_rx: SYNC_STAGES must be 1 to 4");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   rx_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk) begin
            if (rst) sync_q <= 1'b1;
            else     sync_q <= rx;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '1;
            else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx};
         end
      end
   endgenerate

   assign rx_s = sync_q[SYNC_STAGES-1];

   rx_state_t         state;
   logic [OS_CW-1:0]  os_cnt;
   logic [BIT_CW-1:0] bit_cnt;
   logic [BYTE_W-1:0] shift;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= RX_IDLE;
         os_cnt     <= '0;
         bit_cnt    <= '0;
         shift      <= '0;
         rx_prev    <= 1'b1;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         rx_prev    <= rx_s;
         byte_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (rx_prev && !rx_s) begin
                  state  <= RX_START;
                  os_cnt <= '0;
               end
            end
            RX_START: begin
               if (os_tick) begin
                  if (os_cnt == OS_CW'(HALF - 1)) begin
                     os_cnt  <= '0;
                     bit_cnt <= '0;
                     state   <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (os_tick) begin
                  if (os_cnt == OS_CW'(OVERSAMPLE - 1)) begin
                     os_cnt <= '0;
                     shift  <= {rx_s, shift[BYTE_W-1:1]};
                     if (bit_cnt == BIT_CW'(BYTE_W - 1)) state <= RX_STOP;
                     else                                bit_cnt <= bit_cnt + 1'b1;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (os_tick) begin
                  if (os_cnt == OS_CW'(OVERSAMPLE - 1)) begin
                     os_cnt <= '0;
                     state  <= RX_IDLE;
                     if (rx_s) begin
                        byte_valid <= 1'b1;
                        byte_data  <= shift;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R1: a character completes as a single-cycle strobe
   a_r1_valid_pulse : assert property (@(posedge clk) disable iff (rst)
      byte_valid |=> !byte_valid);
   // R2: a strobe follows only a stop bit sampled high
   a_r2_stop_high : assert property (@(posedge clk) disable iff (rst)
      byte_valid |-> ($past(rx_s) && $past(state) == RX_STOP));
   // R1: a start bit sampled high at mid-bit returns to idle
   a_r1_false_start : assert property (@(posedge clk) disable iff (rst)
      (state == RX_START && os_tick && os_cnt == OS_CW'(HALF - 1) && rx_s)
      |=> state == RX_IDLE);
endmodule

// File: rtl/rfc_frame_win.sv
module rfc_frame_win
   import relay_frame_pkg::*;
#(
   parameter int unsigned WINDOW_TICKS = 65536
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_tick,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic [BYTE_W-1:0] relay_lo,
   output logic [BYTE_W-1:0] relay_hi,
   output logic              frame_ok,
   output logic              frame_err
);
   localparam int unsigned WIN_CW = $clog2(WINDOW_TICKS);
   localparam int unsigned IDX_W  = $clog2(FRAME_LEN + 1);
   localparam int unsigned SLOT_W = $clog2(FRAME_LEN);

   generate
      if (WINDOW_TICKS < 2) begin : g_bad_win
         $error("rfc_frame_win: WINDOW_TICKS must be at least 2");
      end
      if (FRAME_LEN != 4) begin : g_bad_len
         $error("rfc_frame_win: frame layout assumes four slots");
      end
   endgenerate

   win_state_t        state;
   logic [WIN_CW-1:0] win_cnt;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] slot [FRAME_LEN];
   logic              frame_good;

   assign frame_good = (slot[0] == SYNC_CODE) && (slot[FRAME_LEN-1] == END_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= W_IDLE;
         win_cnt   <= '0;
         idx       <= '0;
         relay_lo  <= '0;
         relay_hi  <= '0;
         frame_ok  <= 1'b0;
         frame_err <= 1'b0;
         for (int i = 0; i < FRAME_LEN; i++) slot[i] <= '0;
      end else begin
         frame_ok  <= 1'b0;
         frame_err <= 1'b0;
         case (state)
            W_IDLE: begin
               if (byte_valid) begin
                  for (int i = 1; i < FRAME_LEN; i++) slot[i] <= '0;
                  slot[0] <= byte_data;
                  idx     <= IDX_W'(1);
                  win_cnt <= '0;
                  state   <= W_COLLECT;
               end
            end
            W_COLLECT: begin
               if (byte_valid && idx < IDX_W'(FRAME_LEN)) begin
                  slot[idx[SLOT_W-1:0]] <= byte_data;
                  idx <= idx + 1'b1;
               end
               if (win_tick) begin
                  if (win_cnt == WIN_CW'(WINDOW_TICKS - 1)) state <= W_CHECK;
                  else                                      win_cnt <= win_cnt + 1'b1;
               end
            end
            W_CHECK: begin
               if (frame_good) begin
                  relay_lo <= slot[1];
                  relay_hi <= slot[2];
                  frame_ok <= 1'b1;
               end else begin
                  for (int i = 0; i < FRAME_LEN; i++) slot[i] <= '0;
                  frame_err <= 1'b1;
               end
               state <= W_IDLE;
            end
            default: state <= W_IDLE;
         endcase
      end
   end

   // R3: a character seen while idle opens the window with a cleared store
   a_r3_window_opens : assert property (@(posedge clk) disable iff (rst)
      (state == W_IDLE && byte_valid) |=>
      (state == W_COLLECT && slot[0] == $past(byte_data) && win_cnt == '0
       && slot[FRAME_LEN-1] == '0));
   // R4: judgement happens only after a timer tick ends the window
   a_r4_judge_on_expiry : assert property (@(posedge clk) disable iff (rst)
      (state == W_CHECK) |-> ($past(win_tick) && $past(state) == W_COLLECT));
   // R5: relays move only together with an accept pulse
   a_r5_relay_lo_on_ok : assert property (@(posedge clk) disable iff (rst)
      !$stable(relay_lo) |-> frame_ok);
   a_r5_relay_hi_on_ok : assert property (@(posedge clk) disable iff (rst)
      !$stable(relay_hi) |-> frame_ok);
   // R6: a reject leaves the store empty
   a_r6_err_clears : assert property (@(posedge clk) disable iff (rst)
      frame_err |-> (slot[0] == '0 && slot[1] == '0 && slot[2] == '0 && slot[3] == '0));
   // R7: a full store never advances its index
   a_r7_no_overflow : assert property (@(posedge clk) disable iff (rst)
      (state == W_COLLECT && idx == IDX_W'(FRAME_LEN)) |=> idx == IDX_W'(FRAME_LEN));
   // R8: the first cycle after reset shows dark relays
   a_r8_reset_dark : assert property (@(posedge clk)
      $past(rst) |-> (relay_lo == '0 && relay_hi == '0 && !frame_ok && !frame_err));
   // R9: status pulses are exclusive, single-cycle and follow a judgement
   a_r9_exclusive : assert property (@(posedge clk) disable iff (rst)
      !(frame_ok && frame_err));
   a_r9_from_check : assert property (@(posedge clk) disable iff (rst)
      (frame_ok || frame_err) |-> $past(state) == W_CHECK);
   a_r9_single : assert property (@(posedge clk) disable iff (rst)
      (frame_ok || frame_err) |=> !(frame_ok || frame_err));
endmodule

// File: rtl/relay_frame_ctrl.sv
module relay_frame_ctrl
   import relay_frame_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 100_000_000,
   parameter int unsigned BAUD         = 9600,
   parameter int unsigned OVERSAMPLE   = 16,
   parameter int unsigned WIN_TICK_DIV = 108,
   parameter int unsigned WINDOW_TICKS = 65536,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_line,
   output logic [7:0] relay_lo,
   output logic [7:0] relay_hi,
   output logic       frame_ok,
   output logic       frame_err
);
   localparam int unsigned OS_DIV = CLK_HZ / (BAUD * OVERSAMPLE);

   generate
      if (OS_DIV < 2) begin : g_bad_rate
         $error("relay_frame_ctrl: clock too slow for BAUD*OVERSAMPLE");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("relay_frame_ctrl: relay banks are eight bits wide");
      end
   endgenerate

   logic              os_tick;
   logic              win_tick;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_data;

   rfc_tick_gen #(.DIV(OS_DIV)) u_os_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (os_tick)
   );

   rfc_tick_gen #(.DIV(WIN_TICK_DIV)) u_win_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (win_tick)
   );

   rfc_uart_rx #(
      .OVERSAMPLE  (OVERSAMPLE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk        (clk),
      .rst        (rst),
      .os_tick    (os_tick),
      .rx         (rx_line),
      .byte_valid (byte_valid),
      .byte_data  (byte_data)
   );

   rfc_frame_win #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
      .clk        (clk),
      .rst        (rst),
      .win_tick   (win_tick),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .relay_lo   (relay_lo),
      .relay_hi   (relay_hi),
      .frame_ok   (frame_ok),
      .frame_err  (frame_err)
   );
endmodule

// File: tb/relay_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module relay_frame_ctrl_tb_top;
   localparam int BIT_CYC = 64;   // 4 clocks per oversample tick x 16

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic [7:0] relay_lo, relay_hi;
   logic       frame_ok, frame_err;

   always #5 clk = ~clk;

   relay_frame_ctrl #(
      .CLK_HZ(1_600_000), .BAUD(25_000), .OVERSAMPLE(16),
      .WIN_TICK_DIV(4), .WINDOW_TICKS(1024), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst(rst), .rx_line(rx_line),
      .relay_lo(relay_lo), .relay_hi(relay_hi),
      .frame_ok(frame_ok), .frame_err(frame_err)
   );

   typedef struct packed {
      logic       ok;
      logic [7:0] lo;
      logic [7:0] hi;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   logic [7:0] mdl_lo = 8'h00, mdl_hi = 8'h00;

   task automatic check(input bit cond, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: pops one expectation per status pulse
   always @(negedge clk) begin
      if (!rst && (frame_ok || frame_err)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected status pulse",
                  {14'd0, frame_ok, frame_err}, 16'h0000);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(frame_ok == e.ok && frame_err == !e.ok &&
                  relay_lo == e.lo && relay_hi == e.hi, t,
                  "ok,lo,hi",
                  {7'd0, frame_ok, relay_lo} ^ {8'd0, 8'd0} | {relay_hi, 8'd0} & 16'h0,
                  16'h0);
            if (!(frame_ok == e.ok && relay_lo == e.lo && relay_hi == e.hi))
               $display("     detail %s: actual ok=%0b lo=%h hi=%h expected ok=%0b lo=%h hi=%h",
                        t, frame_ok, relay_lo, relay_hi, e.ok, e.lo, e.hi);
         end
      end
   end

   task automatic push_expect(input bit ok, input string tag);
      exp_t e;
      e.ok = ok;
      e.lo = mdl_lo;
      e.hi = mdl_hi;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit stop_ok);
      @(negedge clk) rx_line = 1'b0;
      repeat (BIT_CYC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         repeat (BIT_CYC) @(negedge clk);
      end
      rx_line = stop_ok;
      repeat (BIT_CYC) @(negedge clk);
      rx_line = 1'b1;
      repeat (BIT_CYC) @(negedge clk);
   endtask

   task automatic wait_results(input string req);
      int t = 0;
      while (exp_q.size() != 0 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      check(exp_q.size() == 0, req, "result pulse missing",
            16'(exp_q.size()), 16'd0);
      exp_q.delete();
      tag_q.delete();
      repeat (200) @(negedge clk);
   endtask

   task automatic good_frame(input logic [7:0] d1, input logic [7:0] d2,
                             input string tag);
      mdl_lo = d1;
      mdl_hi = d2;
      push_expect(1'b1, tag);
      send_byte(8'h0A, 1'b1);
      send_byte(d1, 1'b1);
      send_byte(d2, 1'b1);
      send_byte(8'h0D, 1'b1);
      wait_results(tag);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      // R8: reset state
      check(relay_lo == 8'h00 && relay_hi == 8'h00 && !frame_ok && !frame_err,
            "R8", "reset relays", {relay_hi, relay_lo}, 16'h0000);
      rst = 1'b0;
      repeat (50) @(negedge clk);

      // R2: a lone sync character with a bad stop bit opens nothing
      send_byte(8'h0A, 1'b0);
      repeat (6000) @(negedge clk);
      check(relay_lo == 8'h00 && relay_hi == 8'h00, "R2", "relays after bad-stop byte",
            {relay_hi, relay_lo}, 16'h0000);

      // R4 and R5: a valid frame, judged only at expiry
      mdl_lo = 8'h5A;
      mdl_hi = 8'hC3;
      push_expect(1'b1, "R5");
      send_byte(8'h0A, 1'b1);
      send_byte(8'h5A, 1'b1);
      send_byte(8'hC3, 1'b1);
      send_byte(8'h0D, 1'b1);
      repeat (20) @(negedge clk);
      check(relay_lo == 8'h00 && relay_hi == 8'h00 && exp_q.size() == 1, "R4",
            "relays before window expiry", {relay_hi, relay_lo}, 16'h0000);
      wait_results("R5");

      // R6: bad sync byte, relays hold
      push_expect(1'b0, "R6");
      send_byte(8'h0B, 1'b1);
      send_byte(8'h11, 1'b1);
      send_byte(8'h22, 1'b1);
      send_byte(8'h0D, 1'b1);
      wait_results("R6");

      // R6: bad end byte, relays hold
      push_expect(1'b0, "R6");
      send_byte(8'h0A, 1'b1);
      send_byte(8'h11, 1'b1);
      send_byte(8'h22, 1'b1);
      send_byte(8'h0E, 1'b1);
      wait_results("R6");

      // R3 and R10: short frame after an accepted one must not reuse old end byte
      good_frame(8'hFF, 8'h00, "R5");
      push_expect(1'b0, "R10");
      send_byte(8'h0A, 1'b1);
      send_byte(8'h33, 1'b1);
      send_byte(8'h44, 1'b1);
      wait_results("R10");

      // R2: bad stop bit inside a window drops only that character (R3 order)
      mdl_lo = 8'h81;
      mdl_hi = 8'h18;
      push_expect(1'b1, "R2");
      send_byte(8'h0A, 1'b1);
      send_byte(8'h77, 1'b0);
      send_byte(8'h81, 1'b1);
      send_byte(8'h18, 1'b1);
      send_byte(8'h0D, 1'b1);
      wait_results("R2");

      // R7: a fifth character is dropped and opens no new window
      mdl_lo = 8'h00;
      mdl_hi = 8'hFF;
      push_expect(1'b1, "R7");
      send_byte(8'h0A, 1'b1);
      send_byte(8'h00, 1'b1);
      send_byte(8'hFF, 1'b1);
      send_byte(8'h0D, 1'b1);
      send_byte(8'h0A, 1'b1);
      wait_results("R7");
      repeat (5000) @(negedge clk);
      check(relay_lo == 8'h00 && relay_hi == 8'hFF, "R7", "relays after quiet interval",
            {relay_hi, relay_lo}, 16'hFF00);

      // R1: short low glitch is not a start bit
      @(negedge clk) rx_line = 1'b0;
      repeat (10) @(negedge clk);
      rx_line = 1'b1;
      repeat (2000) @(negedge clk);
      check(relay_lo == 8'h00 && relay_hi == 8'hFF, "R1", "relays after glitch",
            {relay_hi, relay_lo}, 16'hFF00);

      // R1: asymmetric patterns confirm bit order
      good_frame(8'hA5, 8'h96, "R1");
      good_frame(8'h01, 8'h80, "R1");

      // R9: nothing left outstanding
      check(exp_q.size() == 0, "R9", "outstanding expectations", 16'(exp_q.size()), 16'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog expired: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule